// File: doc/BRIEF.md
# Masked Two-Bank Register File

This block holds eight 8-bit registers split into two banks of four: a general bank and a temporary bank. All eight registers share one data input and one 2-bit operation code. Each bank has its own 4-bit active-low mask. On a clock edge, every register whose mask bit is low performs the selected operation. The operation can be decrement, increment, load from the data input, or clear. Any subset of the eight registers can be updated in one cycle.

Two read ports operate independently. Each uses a 3-bit selector that can address any of the eight registers. Both ports are combinational views of the stored values, so a write becomes visible on them only after the edge that performs it. An asynchronous active-low reset clears every register.

Top module: `dbrf_top`

## Requirements
- R1: While rst_ni is low, all eight registers are cleared to 0x00, and both read ports then show 0x00 for every select code.
- R2: Operation code 10 loads data_i into every enabled register on the next rising edge.
- R3: Operation code 01 adds one to every enabled register, wrapping from 0xFF to 0x00.
- R4: Operation code 00 subtracts one from every enabled register, wrapping from 0x00 to 0xFF.
- R5: Operation code 11 clears every enabled register to 0x00.
- R6: A register whose mask bit is high keeps its value, whatever the operation code and data input are.
- R7: In each mask, bit 3 enables register 1 of its bank, bit 2 register 2, bit 1 register 3 and bit 0 register 4, and a 0 bit enables. For example, a general mask of 1001 with increment changes only general registers 2 and 3.
- R8: A mask of 0000 enables all four registers of its bank, and a mask of 1111 enables none of them.
- R9: The general and temporary masks act in the same cycle, independently of each other, and both banks use the one shared operation code.
- R10: On both read ports, select codes 000 to 011 return general registers 1 to 4, and codes 100 to 111 return temporary registers 1 to 4.
- R11: A read port shows the value held before an edge up to that edge, and the updated value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fun_i | input | 2 | Operation code: 00 dec, 01 inc, 10 load, 11 clear |
| data_i | input | 8 | Load data |
| gp_mask_ni | input | 4 | General bank mask, active low |
| tp_mask_ni | input | 4 | Temporary bank mask, active low |
| rd_a_sel_i | input | 3 | Read port A select |
| rd_b_sel_i | input | 3 | Read port B select |
| rd_a_o | output | 8 | Read port A data |
| rd_b_o | output | 8 | Read port B data |

## Verification
Two things can happen in the same cycle: an update to the general bank and an update to the temporary bank. Both are driven by the one shared operation code but gated by separate masks. The bench drives random mask pairs, codes and data, including pairs where one bank is fully open and the other fully closed. After each edge it reads all eight registers through both ports and compares them with a bench model. That comparison also judges whether a port still shows the old value just before the edge.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;
  typedef enum logic [1:0] {
    FN_DEC  = 2'b00,
    FN_INC  = 2'b01,
    FN_LOAD = 2'b10,
    FN_CLR  = 2'b11
  } fn_e;
endpackage

// File: rtl/dbrf_cell.sv
module dbrf_cell
  import dbrf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  fn_e          fun_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (en_i) begin
      unique case (fun_i)
        FN_DEC:  q_q <= q_q - W'(1);
        FN_INC:  q_q <= q_q + W'(1);
        FN_LOAD: q_q <= d_i;
        FN_CLR:  q_q <= '0;
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R6
  AST_LOAD_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fun_i == FN_LOAD) |=> q_o == $past(d_i)); // R2
  AST_INC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fun_i == FN_INC) |=> q_o == W'($past(q_o) + W'(1))); // R3
  AST_DEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fun_i == FN_DEC) |=> q_o == W'($past(q_o) - W'(1))); // R4
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fun_i == FN_CLR) |=> q_o == '0); // R5
endmodule

// File: rtl/dbrf_mask_dec.sv
module dbrf_mask_dec #(
  parameter int N = 4
) (
  input  logic [N-1:0] mask_ni,
  output logic [N-1:0] en_o
);
  // highest mask bit enables register index 0
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign en_o[i] = ~mask_ni[N-1-i];
  end

  always_comb begin
    AST_FULL_MASK: assert ((mask_ni != '1) || (en_o == '0)); // R8
  end
endmodule

// File: rtl/dbrf_read_mux.sv
module dbrf_read_mux #(
  parameter int W     = 8,
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0][W-1:0] gp_i,
  input  logic [N-1:0][W-1:0] tp_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        rd_o
);
  localparam int IDX_W = SEL_W - 1;
  logic [IDX_W-1:0] idx;

  assign idx  = sel_i[IDX_W-1:0];
  assign rd_o = sel_i[SEL_W-1] ? tp_i[idx] : gp_i[idx];
endmodule

// File: rtl/dbrf_top.sv
module dbrf_top
  import dbrf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_N = 4,
  parameter int SEL_W  = $clog2(2 * BANK_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fun_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BANK_N-1:0] gp_mask_ni,
  input  logic [BANK_N-1:0] tp_mask_ni,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  fn_e fun;
  logic [BANK_N-1:0] gp_en, tp_en;
  logic [BANK_N-1:0][DATA_W-1:0] gp_q, tp_q;

  assign fun = fn_e'(fun_i);

  dbrf_mask_dec #(.N(BANK_N)) u_gp_dec (.mask_ni(gp_mask_ni), .en_o(gp_en));
  dbrf_mask_dec #(.N(BANK_N)) u_tp_dec (.mask_ni(tp_mask_ni), .en_o(tp_en));

  for (genvar i = 0; i < BANK_N; i++) begin : g_reg
    dbrf_cell #(.W(DATA_W)) u_gp (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(gp_en[i]), .fun_i(fun),
      .d_i(data_i), .q_o(gp_q[i]));
    dbrf_cell #(.W(DATA_W)) u_tp (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tp_en[i]), .fun_i(fun),
      .d_i(data_i), .q_o(tp_q[i]));
  end

  dbrf_read_mux #(.W(DATA_W), .N(BANK_N), .SEL_W(SEL_W)) u_rd_a (
    .gp_i(gp_q), .tp_i(tp_q), .sel_i(rd_a_sel_i), .rd_o(rd_a_o));
  dbrf_read_mux #(.W(DATA_W), .N(BANK_N), .SEL_W(SEL_W)) u_rd_b (
    .gp_i(gp_q), .tp_i(tp_q), .sel_i(rd_b_sel_i), .rd_o(rd_b_o));

  AST_SAME_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sel_i == rd_b_sel_i) |-> rd_a_o == rd_b_o); // R10
  AST_GP_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gp_mask_ni == '1) |=> $stable(gp_q)); // R8
endmodule

// File: tb/dbrf_top_tb.sv
module dbrf_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] fun_i = 2'b00;
  logic [7:0] data_i = 8'h00;
  logic [3:0] gp_mask_ni = 4'hF, tp_mask_ni = 4'hF;
  logic [2:0] rd_a_sel_i = 3'd0, rd_b_sel_i = 3'd0;
  logic [7:0] rd_a_o, rd_b_o;

  int n_chk = 0, n_err = 0;
  logic [7:0] gp_m [4];
  logic [7:0] tp_m [4];

  always #10 clk_i = ~clk_i;

  dbrf_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fun_i(fun_i), .data_i(data_i),
    .gp_mask_ni(gp_mask_ni), .tp_mask_ni(tp_mask_ni),
    .rd_a_sel_i(rd_a_sel_i), .rd_b_sel_i(rd_b_sel_i),
    .rd_a_o(rd_a_o), .rd_b_o(rd_b_o));

  function automatic logic [7:0] nxt(logic [1:0] f, logic [7:0] q, logic [7:0] d);
    case (f)
      2'b00:   return q - 8'd1;
      2'b01:   return q + 8'd1;
      2'b10:   return d;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string fn_tag(logic [1:0] f);
    case (f)
      2'b00:   return "R4";
      2'b01:   return "R3";
      2'b10:   return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mdl(int s);
    return (s < 4) ? gp_m[s] : tp_m[s-4];
  endfunction

  // read all eight on both ports; B walks in reverse order
  task automatic sweep(string tag);
    for (int s = 0; s < 8; s++) begin
      rd_a_sel_i = 3'(s);
      rd_b_sel_i = 3'(7 - s);
      #1;
      chk(tag, rd_a_o, mdl(s));
      chk({tag, "/R10"}, rd_b_o, mdl(7 - s));
    end
  endtask

  // drive at negedge, check old value before edge, update model, sweep after
  task automatic op(logic [1:0] f, logic [7:0] d, logic [3:0] gm, logic [3:0] tm, string tag);
    @(negedge clk_i);
    fun_i = f; data_i = d; gp_mask_ni = gm; tp_mask_ni = tm;
    rd_a_sel_i = 3'd0; rd_b_sel_i = 3'd4;
    #1;
    chk("R11", rd_a_o, gp_m[0]);
    chk("R11", rd_b_o, tp_m[0]);
    for (int i = 0; i < 4; i++) begin
      if (!gm[3-i]) gp_m[i] = nxt(f, gp_m[i], d);
      if (!tm[3-i]) tp_m[i] = nxt(f, tp_m[i], d);
    end
    @(posedge clk_i);
    #2;
    sweep(tag);
    gp_mask_ni = 4'hF; tp_mask_ni = 4'hF;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    for (int i = 0; i < 4; i++) begin gp_m[i] = 8'h00; tp_m[i] = 8'h00; end
    repeat (3) @(negedge clk_i);
    sweep("R1");
    rst_ni = 1'b1;
    op(2'b10, 8'h55, 4'b0000, 4'b0000, "R2/R8");
    op(2'b01, 8'hAA, 4'b1001, 4'b1111, "R7");
    op(2'b10, 8'hFF, 4'b0111, 4'b1110, "R9");
    op(2'b01, 8'h00, 4'b0111, 4'b1110, "R3");
    op(2'b11, 8'h12, 4'b1100, 4'b0011, "R5");
    op(2'b00, 8'h34, 4'b0000, 4'b0000, "R4");
    op(2'b10, 8'hC3, 4'b1111, 4'b1111, "R6/R8");
    op(2'b01, 8'h99, 4'b1111, 4'b0000, "R9");
    for (int k = 0; k < 300; k++) begin
      logic [1:0] f;
      f = 2'($urandom);
      op(f, 8'($urandom), 4'($urandom), 4'($urandom), fn_tag(f));
    end
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin gp_m[i] = 8'h00; tp_m[i] = 8'h00; end
    #1;
    sweep("R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule